// File: doc/BRIEF.md
# H-Bridge Commutation Sequencer

This block is the digital core of a full-bridge gate controller. It drives four gate-enable levels: high-left, high-right, low-left and low-right. It takes five asynchronous control levels:

- a power-good level from an external hysteretic supply comparator,
- a start-up delay enable,
- a divider-off select,
- a bridge-disable request,
- a commutation clock from either an on-chip or an off-chip oscillator.

From these it derives a target bridge pattern. A non-overlap stage then applies that pattern so that a conducting pair is always switched off before the next pair is switched on.

Before supply release the block holds both low-side switches on so the bootstrap capacitors can charge. Once power-good and the delay enable are both high, it commutates between two diagonal positions. With the divider active, the position flips on each falling clock edge, starting from a fixed first position. With the divider off, the position follows the clock level. A disable request removes all drive and takes priority over every other state.

Top module: `hb_commutator`

## Requirements
- R1: While bridge-disable is high, all four gate outputs are low, whatever the other inputs are, including before power-good. Outputs go low within three clock cycles of the request.
- R2: While power-good is low and disable is low, the outputs show the pre-charge pattern: both low sides on and both high sides off ({hl,hr,ll,lr} = 0011). The delay enable has no effect in this state.
- R3: With power-good high and the delay enable low, the pre-charge pattern is held. Commutation begins only after the delay enable goes high.
- R4: During commutation only two patterns appear. Position A is high-left and low-right on (1001). Position B is high-right and low-left on (0110).
- R5: With the divider active (divider-off low), the position toggles once on each falling edge of the commutation clock. Rising edges leave it unchanged.
- R6: With the divider active, the first position is A on every entry to commutation: after power-up, after disable is released, and after the delay enable returns high.
- R7: With the divider off, a high clock gives position B and a low clock gives position A, including on the first entry.
- R8: If power-good falls, the block returns to the pre-charge pattern, and both high sides are off on the next cycle.
- R9: A turn-off is applied at once. A turn-on waits until the outgoing devices have been off for DEAD_CYC+1 clock cycles. The high and low switch of one leg are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Supply released (hysteretic comparator output) |
| su_en_i | input | 1 | Start-up delay enable; high allows commutation |
| div_off_i | input | 1 | High bypasses the divide-by-two |
| bridge_dis_i | input | 1 | High forces all gates off |
| comm_clk_i | input | 1 | Commutation clock |
| gate_hl_o | output | 1 | High-left gate enable |
| gate_hr_o | output | 1 | High-right gate enable |
| gate_ll_o | output | 1 | Low-left gate enable |
| gate_lr_o | output | 1 | Low-right gate enable |

## Verification
The bench checks that rising clock edges are ignored in divided mode. A design that toggled on both edges would run at the clock rate rather than half of it.

It re-enters commutation after a disable, after a delay-enable drop and after a power-good loss. A design that kept its old phase would then start in position B instead of A.

It asserts disable before power-good to catch a design that let pre-charge win over disable. It counts the all-off gap on a pair change. A missing or short non-overlap shows up as a gap shorter than DEAD_CYC+1 cycles or as overlapping legs.

// File: rtl/hb_pkg.sv
package hb_pkg;
  // bit order {hl, hr, ll, lr}
  typedef logic [3:0] gate_t;
  localparam gate_t GATE_OFF   = 4'b0000;
  localparam gate_t GATE_PRE   = 4'b0011;
  localparam gate_t GATE_POS_A = 4'b1001;
  localparam gate_t GATE_POS_B = 4'b0110;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hb_sequencer.sv
module hb_sequencer
  import hb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pg_i,
  input  logic  su_i,
  input  logic  div_off_i,
  input  logic  dis_i,
  input  logic  cclk_i,
  output gate_t tgt_o
);
  logic run_d, run_q, phase_q, cclk_q, cclk_fall;

  assign run_d     = pg_i & su_i & ~dis_i;
  assign cclk_fall = cclk_q & ~cclk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      phase_q <= 1'b0;
      cclk_q  <= 1'b0;
    end else begin
      cclk_q <= cclk_i;
      run_q  <= run_d;
      if (!run_d)                              phase_q <= 1'b0;
      else if (run_q && cclk_fall && !div_off_i) phase_q <= ~phase_q;
    end
  end

  always_comb begin
    if (dis_i)                tgt_o = GATE_OFF;
    else if (!(run_q && run_d)) tgt_o = GATE_PRE;
    else if (div_off_i)       tgt_o = cclk_i  ? GATE_POS_B : GATE_POS_A;
    else                      tgt_o = phase_q ? GATE_POS_B : GATE_POS_A;
  end

  p_first_pos_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(run_q) && run_d && !div_off_i) |-> (tgt_o == GATE_POS_A));

  p_two_pos_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && run_d) |-> (tgt_o == GATE_POS_A || tgt_o == GATE_POS_B));
endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime
  import hb_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  gate_t tgt_i,
  output gate_t gate_o
);
  localparam int CW = (DEAD_CYC > 0) ? $clog2(DEAD_CYC + 1) : 1;

  gate_t         out_q;
  logic [CW-1:0] cnt_q;
  logic          drop;

  assign drop = |(out_q & ~tgt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= GATE_OFF;
      cnt_q <= CW'(DEAD_CYC);
    end else if (drop) begin
      out_q <= out_q & tgt_i;      // turn-offs take effect at once
      cnt_q <= CW'(DEAD_CYC);
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (out_q != tgt_i && cnt_q == '0) out_q <= tgt_i;
    end
  end

  assign gate_o = out_q;

  p_turn_on_wait_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(out_q & ~$past(out_q))) |-> ($past(cnt_q) == '0));
endmodule

// File: rtl/hb_commutator.sv
module hb_commutator
  import hb_pkg::*;
#(
  parameter int DEAD_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic su_en_i,
  input  logic div_off_i,
  input  logic bridge_dis_i,
  input  logic comm_clk_i,
  output logic gate_hl_o,
  output logic gate_hr_o,
  output logic gate_ll_o,
  output logic gate_lr_o
);
  localparam int NIN = 5;

  logic [NIN-1:0] raw, syn;
  logic  pg_s, su_s, dd_s, dis_s, cclk_s;
  gate_t tgt, gate;

  assign raw = {pwr_good_i, su_en_i, div_off_i, bridge_dis_i, comm_clk_i};
  assign {pg_s, su_s, dd_s, dis_s, cclk_s} = syn;

  hb_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  hb_sequencer u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pg_i     (pg_s),
    .su_i     (su_s),
    .div_off_i(dd_s),
    .dis_i    (dis_s),
    .cclk_i   (cclk_s),
    .tgt_o    (tgt)
  );

  hb_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dead (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tgt_i (tgt),
    .gate_o(gate)
  );

  assign {gate_hl_o, gate_hr_o, gate_ll_o, gate_lr_o} = gate;

  p_off_on_dis_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_s |=> (gate == GATE_OFF));

  p_no_shoot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_hl_o && gate_ll_o) && !(gate_hr_o && gate_lr_o));

  p_highs_off_pg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pg_s |=> (!gate_hl_o && !gate_hr_o));

  p_hl_after_ll_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_hl_o) |-> !$past(gate_ll_o));
endmodule

// File: tb/hb_commutator_bench.sv
module hb_commutator_bench;
  localparam int DEAD = 4;
  localparam int NV   = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pg = 0, su = 0, dd = 0, dis = 0, cclk = 0;
  logic hl, hr, ll, lr;
  int   n_chk = 0, n_fail = 0;
  bit   shoot = 0;

  always #2 clk = ~clk;

  hb_commutator #(.DEAD_CYC(DEAD)) u_hb_commutator (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pg), .su_en_i(su),
    .div_off_i(dd), .bridge_dis_i(dis), .comm_clk_i(cclk),
    .gate_hl_o(hl), .gate_hr_o(hr), .gate_ll_o(ll), .gate_lr_o(lr)
  );

  // {pg, su, dd, dis, cclk, expected {hl,hr,ll,lr}, req tag}
  typedef struct packed {
    logic [4:0] in;
    logic [3:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VT [NV] = '{
    '{5'b00000, 4'b0011, 4'd2},   // R2 pre-charge
    '{5'b01000, 4'b0011, 4'd2},   // R2 delay enable ignored
    '{5'b01010, 4'b0000, 4'd1},   // R1 over start-up
    '{5'b10000, 4'b0011, 4'd3},   // R3 held by delay
    '{5'b11000, 4'b1001, 4'd6},   // R6 first position A
    '{5'b11001, 4'b1001, 4'd5},   // R5 rising ignored
    '{5'b11000, 4'b0110, 4'd5},   // R5 falling toggles
    '{5'b11001, 4'b0110, 4'd5},
    '{5'b11000, 4'b1001, 4'd4},   // R4
    '{5'b11001, 4'b1001, 4'd5},
    '{5'b11000, 4'b0110, 4'd4},
    '{5'b11010, 4'b0000, 4'd1},   // R1
    '{5'b11000, 4'b1001, 4'd6},   // R6 after disable
    '{5'b11001, 4'b1001, 4'd5},
    '{5'b11000, 4'b0110, 4'd5},
    '{5'b10000, 4'b0011, 4'd3},   // R3 delay low again
    '{5'b11000, 4'b1001, 4'd6},   // R6 after delayed start
    '{5'b11101, 4'b0110, 4'd7},   // R7 level high
    '{5'b11100, 4'b1001, 4'd7},   // R7 level low
    '{5'b11101, 4'b0110, 4'd7},
    '{5'b01101, 4'b0011, 4'd8},   // R8 power loss
    '{5'b11101, 4'b0110, 4'd7},   // R7 entry follows level
    '{5'b01001, 4'b0011, 4'd8},
    '{5'b11001, 4'b1001, 4'd6}    // R6 after power return
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: gates=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk)
    if (rst_n && ((hl && ll) || (hr && lr))) shoot = 1;

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: timeout actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int gap;
    cyc(3);
    check("R9 reset", {hl, hr, ll, lr}, 4'b0000);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      {pg, su, dd, dis, cclk} = VT[v].in;
      cyc(16);
      check($sformatf("R%0d vec%0d", VT[v].req, v), {hl, hr, ll, lr}, VT[v].exp);
    end

    // R9: all-off gap on a pair change, divider off
    {pg, su, dd, dis, cclk} = 5'b11101;
    cyc(16);
    check("R7 setup", {hl, hr, ll, lr}, 4'b0110);
    cclk = 0;
    gap = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(1);
      if ({hl, hr, ll, lr} == 4'b0000) gap++;
    end
    check("R9 gap", 4'(gap), 4'(DEAD + 1));
    check("R9 final", {hl, hr, ll, lr}, 4'b1001);

    // R1 latency: off within three cycles
    dis = 1;
    cyc(3);
    check("R1 latency", {hl, hr, ll, lr}, 4'b0000);
    dis = 0;
    cyc(16);
    check("R7 after disable", {hl, hr, ll, lr}, 4'b1001);

    n_chk++;
    if (shoot) begin
      n_fail++;
      $display("FAIL R9: shoot-through seen actual=1 expected=0");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule